// File: doc/BRIEF.md
# Byte-Mapped BCD Calendar Clock

This block is a calendar clock that lives in the top eight byte addresses of a small memory space. Every address below that window reaches a plain single-port RAM. The host uses one byte-wide protocol for both the RAM and the clock registers: a write strobe with an address and a data byte, or a read strobe with an address. The read data comes back one cycle later on a registered output.

A single-cycle pulse on the tick input advances the time by one second. All eight clock fields hold packed BCD: seconds, minutes, hours, day-of-week, date, month, year and century. The carry chain runs through the whole calendar in the same cycle as the tick. It takes care of 24-hour wrap, month lengths, February in leap years, and a year wrap that increments the century.

Top module: `rtc_memmap`

## Requirements
- R1: With all upper address bits set, `addr[2:0]` picks a clock field: 7 seconds, 6 minutes, 5 hours, 4 day-of-week, 3 date, 2 month, 1 year, 0 century. Any other address reaches the RAM, and a RAM read returns the byte last written there.
- R2: A read strobe in one cycle updates `rdata` at the next clock edge. While no read strobe is present, `rdata` keeps its value.
- R3: After reset `rdata` is 0x00 and the clock reads century 0x20, year 0x00, month 0x01, date 0x01, day-of-week 0x01, and hours, minutes and seconds 0x00.
- R4: Seconds and minutes count in BCD from 00 to 59. A tick at seconds 59 gives 00 and advances minutes, and minutes 59 wrapping advances hours. A tick at 09 gives 10.
- R5: Hours run from 00 to 23. When the time passes 23:59:59 it becomes 00:00:00 and the date and day-of-week both advance.
- R6: Day-of-week counts 01 to 07 and wraps from 07 to 01.
- R7: The date wraps to 01 after 30 in months 04, 06, 09 and 11 and after 31 in the other months except 02, and then the month advances. Month 12 wraps to 01 and advances the year.
- R8: February ends at 29 when the BCD year is divisible by 4 (including 00) and at 28 otherwise.
- R9: Year 99 wrapping to 00 increments the century.
- R10: When a clock write and a tick fall in the same cycle, the written byte is stored and that tick is dropped for all fields.
- R11: RAM writes leave the clock fields unchanged, and clock writes leave the RAM unchanged.
- R12: A byte written to a clock field reads back unchanged as long as no tick occurs in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| addr | input | ADDR_W | Byte address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data |

## Verification
A wrong carry mask or month-length table does not show up until a tick crosses that exact boundary. After that, every later read of the affected field and of the fields above it returns a wrong value. For this reason the bench presets each field just below a boundary, gives a single tick, and reads every field the carry could reach: the failure appears on the first read after that tick, two cycles after the edge. A decode fault that steers writes to the wrong field or into the RAM shows up on the next readback of the neighbouring location.

// File: rtl/rtcmem_pkg.sv
package rtcmem_pkg;
  // field index equals address offset inside the clock window
  localparam int FI_CENT = 0;
  localparam int FI_YEAR = 1;
  localparam int FI_MON  = 2;
  localparam int FI_DATE = 3;
  localparam int FI_DOW  = 4;
  localparam int FI_HOUR = 5;
  localparam int FI_MIN  = 6;
  localparam int FI_SEC  = 7;
  localparam int N_FLD   = 8;

  function automatic logic [7:0] bcd_next(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return v + 8'd1;
  endfunction

  // 10*t + u is divisible by 4 exactly when 2*t + u is
  function automatic logic leap_bcd(input logic [7:0] y);
    logic [4:0] s;
    s = {y[7:4], 1'b0} + 5'(y[3:0]);
    return s[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return leap_bcd(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] fld_lo(input int i);
    case (i)
      FI_MON, FI_DATE, FI_DOW: return 8'h01;
      default:                 return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] fld_hi(input int i);
    case (i)
      FI_SEC, FI_MIN:  return 8'h59;
      FI_HOUR:         return 8'h23;
      FI_DOW:          return 8'h07;
      FI_DATE:         return 8'h31;
      FI_MON:          return 8'h12;
      default:         return 8'h99;
    endcase
  endfunction

  function automatic logic [7:0] fld_rst(input int i);
    case (i)
      FI_CENT:                 return 8'h20;
      FI_MON, FI_DATE, FI_DOW: return 8'h01;
      default:                 return 8'h00;
    endcase
  endfunction

  // set of fields that must all sit at their top value for field i to step
  function automatic logic [N_FLD-1:0] fld_mask(input int i);
    case (i)
      FI_SEC:          return 8'h00;
      FI_MIN:          return 8'h80;
      FI_HOUR:         return 8'hC0;
      FI_DOW, FI_DATE: return 8'hE0;
      FI_MON:          return 8'hE8;
      FI_YEAR:         return 8'hEC;
      default:         return 8'hEE;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtcmem_pkg::*;
#(
  parameter logic [7:0] RST_VAL = 8'h00,
  parameter logic [7:0] LO_VAL  = 8'h00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       step,
  input  logic [7:0] hi,
  output logic [7:0] value,
  output logic       at_top
);
  assign at_top = (value >= hi);

  always_ff @(posedge clk) begin
    if (rst)       value <= RST_VAL;
    else if (load) value <= load_val;
    else if (step) value <= at_top ? LO_VAL : bcd_next(value);
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtcmem_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick,
  input  logic                   wr_en,
  input  logic [2:0]             wr_fld,
  input  logic [7:0]             wdata,
  output logic [N_FLD-1:0][7:0]  fld_q
);
  logic [N_FLD-1:0] at_top;
  logic [N_FLD-1:0] step;
  logic             tick_eff;
  logic [7:0]       date_hi;

  // host write wins: the tick of that cycle is discarded
  assign tick_eff = tick && !wr_en;
  assign date_hi  = month_last(fld_q[FI_MON], fld_q[FI_YEAR]);

  for (genvar i = 0; i < N_FLD; i++) begin : g_fld
    localparam logic [N_FLD-1:0] MASK = fld_mask(i);
    logic [7:0] hi_w;
    assign hi_w    = (i == FI_DATE) ? date_hi : fld_hi(i);
    assign step[i] = tick_eff && ((at_top & MASK) == MASK);

    rtc_bcd_field #(
      .RST_VAL(fld_rst(i)),
      .LO_VAL (fld_lo(i))
    ) u_field (
      .clk     (clk),
      .rst     (rst),
      .load    (wr_en && (wr_fld == 3'(i))),
      .load_val(wdata),
      .step    (step[i]),
      .hi      (hi_w),
      .value   (fld_q[i]),
      .at_top  (at_top[i])
    );

    // R10
    fld_load_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_fld == 3'(i)) |=> (fld_q[i] == $past(wdata)));
  end

  // R12
  cal_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_en) |=> $stable(fld_q));

  // R9
  century_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_en && fld_q[FI_YEAR] == 8'h99 && fld_q[FI_CENT] != 8'h99 &&
     (&at_top[FI_SEC:FI_MON]))
    |=> (fld_q[FI_YEAR] == 8'h00 && fld_q[FI_CENT] != $past(fld_q[FI_CENT])));
endmodule

// File: rtl/rtc_ram.sv
module rtc_ram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  // output register with synchronous reset, as a block RAM offers it
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (re) q <= mem[addr];
  end
endmodule

// File: rtl/rtc_memmap.sv
module rtc_memmap
  import rtcmem_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam int FLD_AW = 3;

  logic                  in_clk;
  logic [N_FLD-1:0][7:0] cal_q;
  logic [7:0]            ram_q;
  logic [7:0]            clk_rd_q;
  logic                  sel_clk_q;

  assign in_clk = &addr[ADDR_W-1:FLD_AW];

  rtc_calendar u_cal (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick_1hz),
    .wr_en (wr_en && in_clk),
    .wr_fld(addr[FLD_AW-1:0]),
    .wdata (wdata),
    .fld_q (cal_q)
  );

  rtc_ram #(.AW(ADDR_W), .DW(8)) u_ram (
    .clk  (clk),
    .rst  (rst),
    .we   (wr_en && !in_clk),
    .re   (rd_en && !in_clk),
    .addr (addr),
    .wdata(wdata),
    .q    (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_rd_q  <= '0;
      sel_clk_q <= 1'b0;
    end else if (rd_en) begin
      sel_clk_q <= in_clk;
      if (in_clk) clk_rd_q <= cal_q[addr[FLD_AW-1:0]];
    end
  end

  assign rdata = sel_clk_q ? clk_rd_q : ram_q;

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  // R11
  ram_iso_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !in_clk && !tick_1hz) |=> $stable(cal_q));
endmodule

// File: tb/test_rtc_memmap.sv
module test_rtc_memmap;
  localparam int AW = 10;
  localparam logic [AW-1:0] CBASE = 10'h3F8;
  localparam int OC = 0, OY = 1, OMO = 2, ODA = 3, ODW = 4, OH = 5, OMI = 6, OS = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_1hz = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;

  int         n_cmp = 0;
  int         n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  rtc_memmap #(.ADDR_W(AW)) i_rtc_memmap (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .addr(addr),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata)
  );

  always #10 clk = ~clk;

  always @(posedge clk) rd_seen <= rd_en;

  function automatic void check(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endfunction

  // monitor: compares each read result one edge after its strobe
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R2: unexpected read result %h expected none", rdata);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  function automatic logic [AW-1:0] ca(int off);
    return CBASE + AW'(off);
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string t);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic tk();
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic set_dt(input logic [7:0] c, y, mo, da, dw, h, mi, s);
    wr(ca(OC), c);  wr(ca(OY), y);   wr(ca(OMO), mo); wr(ca(ODA), da);
    wr(ca(ODW), dw); wr(ca(OH), h);  wr(ca(OMI), mi); wr(ca(OS), s);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R3 rdata after reset", rdata, 8'h00);
    // R3 and R1: reset values at each offset
    rd(ca(OC), 8'h20, "R3 century");
    rd(ca(OY), 8'h00, "R3 year");
    rd(ca(OMO), 8'h01, "R3 month");
    rd(ca(ODA), 8'h01, "R3 date");
    rd(ca(ODW), 8'h01, "R3 dow");
    rd(ca(OH), 8'h00, "R3 hour");
    rd(ca(OMI), 8'h00, "R3 minute");
    rd(ca(OS), 8'h00, "R3 second");

    // R1 / R11: RAM below the window
    wr(10'h000, 8'hA5);
    wr(10'h3F7, 8'h5A);
    rd(10'h000, 8'hA5, "R1 ram low");
    rd(10'h3F7, 8'h5A, "R1 ram just below window");
    rd(ca(OS), 8'h00, "R11 sec after ram write");
    wr(ca(OMI), 8'h33);
    rd(ca(OMI), 8'h33, "R12 minute readback");
    rd(10'h3F7, 8'h5A, "R11 ram after clock write");

    // R4
    wr(ca(OS), 8'h09); tk();
    rd(ca(OS), 8'h10, "R4 sec 09->10");
    wr(ca(OS), 8'h59); wr(ca(OMI), 8'h05); tk();
    rd(ca(OS), 8'h00, "R4 sec wrap");
    rd(ca(OMI), 8'h06, "R4 minute carry");
    rd(ca(OH), 8'h00, "R4 hour untouched");
    wr(ca(OH), 8'h07); wr(ca(OMI), 8'h59); wr(ca(OS), 8'h59); tk();
    rd(ca(OH), 8'h08, "R4 minute wrap to hour");
    rd(ca(OMI), 8'h00, "R4 minute wrap");

    // R5 / R6
    set_dt(8'h20, 8'h23, 8'h06, 8'h15, 8'h07, 8'h23, 8'h59, 8'h59); tk();
    rd(ca(OH), 8'h00, "R5 hour wrap");
    rd(ca(ODA), 8'h16, "R5 date advance");
    rd(ca(ODW), 8'h01, "R6 dow 07->01");
    rd(ca(OMO), 8'h06, "R5 month untouched");
    wr(ca(ODW), 8'h03); wr(ca(OH), 8'h23); wr(ca(OMI), 8'h59); wr(ca(OS), 8'h59); tk();
    rd(ca(ODW), 8'h04, "R6 dow 03->04");

    // R7
    set_dt(8'h20, 8'h23, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59); tk();
    rd(ca(ODA), 8'h01, "R7 april end");
    rd(ca(OMO), 8'h05, "R7 month after april");
    set_dt(8'h20, 8'h23, 8'h12, 8'h31, 8'h02, 8'h23, 8'h59, 8'h59); tk();
    rd(ca(ODA), 8'h01, "R7 dec date wrap");
    rd(ca(OMO), 8'h01, "R7 month wrap");
    rd(ca(OY), 8'h24, "R7 year advance");
    rd(ca(OC), 8'h20, "R7 century untouched");

    // R8
    set_dt(8'h20, 8'h24, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59); tk();
    rd(ca(ODA), 8'h29, "R8 leap feb 28->29");
    wr(ca(OH), 8'h23); wr(ca(OMI), 8'h59); wr(ca(OS), 8'h59); tk();
    rd(ca(ODA), 8'h01, "R8 leap feb 29 wrap");
    rd(ca(OMO), 8'h03, "R8 leap to march");
    set_dt(8'h20, 8'h23, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59); tk();
    rd(ca(ODA), 8'h01, "R8 common feb wrap");
    rd(ca(OMO), 8'h03, "R8 common to march");
    set_dt(8'h20, 8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59); tk();
    rd(ca(ODA), 8'h29, "R8 year 00 is leap");
    set_dt(8'h20, 8'h10, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59); tk();
    rd(ca(ODA), 8'h01, "R8 year 10 not leap");

    // R9
    set_dt(8'h20, 8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59); tk();
    rd(ca(OY), 8'h00, "R9 year wrap");
    rd(ca(OC), 8'h21, "R9 century step");
    rd(ca(OMO), 8'h01, "R9 month");

    // R10
    wr(ca(OMI), 8'h10); wr(ca(OS), 8'h30);
    addr = ca(OS); wdata = 8'h45; wr_en = 1'b1; tick_1hz = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_1hz = 1'b0;
    rd(ca(OS), 8'h45, "R10 write wins over tick");
    rd(ca(OMI), 8'h10, "R10 minute unchanged");
    wr(ca(OS), 8'h59);
    addr = ca(OH); wdata = 8'h12; wr_en = 1'b1; tick_1hz = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_1hz = 1'b0;
    rd(ca(OS), 8'h59, "R10 tick dropped for other fields");

    // R2: hold without a strobe
    rd(ca(OH), 8'h12, "R2 read hour");
    addr = 10'h000;
    repeat (2) @(negedge clk);
    check("R2 rdata held", rdata, 8'h12);
    rd(10'h000, 8'hA5, "R11 ram kept through clock traffic");

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R2: %0d reads unanswered expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #4000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run hung got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule